// File: doc/BRIEF.md
# Down-Counting Interval Timer with Bus Registers

This block is a single-channel interval timer reached over a simple 32-bit register bus (address, write strobe, write data, combinational read data). Software programs a 64-bit reload value as two words, then starts the counter through a control register. While it runs, the counter steps down by one on every cycle in which the `tick` enable is high. When a tick arrives while the count is zero, the block records an expiry in a pending flag. The block then either reloads and keeps running (periodic mode) or parks at zero (single-shot mode).

The pending flag is cleared by writing a one to it. It drives a level interrupt through a mask bit in the control register. The address of the control register is set by a parameter, so the block fits either of two register layouts. The live 64-bit count can be read back at any time as two words.

Top module: `cdown_timer`

## Requirements
- R1: After reset every register reads zero (reload words, count words, control, pending flag), the counter is stopped and `irq` is low.
- R2: Register byte offsets: reload low word 0x00, reload high word 0x04, count low word 0x08, count high word 0x0C, pending flag 0x18 (bit 0). Control is at 0x10 when `CTRL_AT_1C` is 0 and at 0x1C when it is 1. Any other offset reads zero. Reload and control read back what was written.
- R3: Control bit 0 is the run bit. On the cycle after a write turns it from 0 to 1, the counter takes the full 64-bit reload value. Rewriting control while the run bit is already 1 does not reload.
- R4: While the run bit is 1, the count drops by one on each cycle with `tick` high and holds on cycles with `tick` low. After control is written with 0 the count freezes.
- R5: With control bit 1 at 0 (periodic), a tick that finds the count at zero sets the pending flag and reloads. A reload value of N therefore gives one expiry every N+1 ticks.
- R6: With control bit 1 at 1 (single-shot), a tick at zero sets the pending flag once, and the count then stays at zero. The run bit is left at 1. Only a 0-then-1 write of the run bit starts a new count.
- R7: Writing the pending-flag register with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged.
- R8: If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R9: `irq` equals the pending flag ANDed with control bit 2 (unmask).
- R10: The count is a true 64-bit value: a borrow from the low word decrements the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one step per cycle when high |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, pending flag AND unmask |

## Verification
The bench measures the expiry period exactly, so a counter that fires after N ticks instead of N+1 shows up as a pending flag seen one window early or late. It places a clearing write on the same cycle as an expiry; a design where the clear wins reads back zero. It rewrites control while the counter is running and checks the count afterwards, which catches a design that reloads on every write instead of only on the rising edge of the run bit. It also runs single-shot mode past expiry: a design that re-fires at zero sets the flag again after it was cleared, and a design that wraps to the top of the range shows a non-zero count.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   // byte offsets of the register file
   localparam int unsigned OFS_LOAD_LO = 32'h00;
   localparam int unsigned OFS_LOAD_HI = 32'h04;
   localparam int unsigned OFS_CNT_LO  = 32'h08;
   localparam int unsigned OFS_CNT_HI  = 32'h0C;
   localparam int unsigned OFS_CTRL_A  = 32'h10;
   localparam int unsigned OFS_STAT    = 32'h18;
   localparam int unsigned OFS_CTRL_B  = 32'h1C;

   localparam int unsigned CTRL_BITS = 3;

   // control register, bit 0 = run, bit 1 = single-shot, bit 2 = unmask
   typedef struct packed {
      logic unmask;
      logic oneshot;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/cdt_core.sv
module cdt_core
   import cdt_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  ctrl_t            ctrl_i,
   input  logic [CNT_W-1:0] load_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_d;
   logic             parked_q;
   logic             start;
   logic             step;
   logic             at_zero;

   assign start   = ctrl_i.run & ~run_d;
   assign step    = ctrl_i.run & run_d & tick;
   assign at_zero = (cnt_q == '0);

   // an expiry is suppressed only while a single-shot count sits parked
   assign expire_o = step & at_zero & ~(ctrl_i.oneshot & parked_q);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         run_d    <= 1'b0;
         parked_q <= 1'b0;
      end else begin
         run_d <= ctrl_i.run;
         if (start) begin
            cnt_q    <= load_i;
            parked_q <= 1'b0;
         end else if (step) begin
            if (!at_zero) begin
               cnt_q <= cnt_q - 1'b1;
            end else if (ctrl_i.oneshot) begin
               parked_q <= 1'b1;
            end else begin
               cnt_q <= load_i;
            end
         end
      end
   end

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i.run && !run_d) |=> (cnt_q == $past(load_i)));

   // R4
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i.run) |=> $stable(cnt_q));

   // R4
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i.run && run_d && !tick) |=> $stable(cnt_q));

   // R5
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_zero && !ctrl_i.oneshot) |=> (cnt_q == $past(load_i)));

   // R6
   oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_zero && ctrl_i.oneshot) |=> (cnt_q == '0));

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
   import cdt_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 5,
   parameter bit          CTRL_AT_1C = 1'b0,
   localparam int unsigned CNT_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              expire_i,
   output logic [CNT_W-1:0]  load_o,
   output ctrl_t             ctrl_o,
   output logic              flag_o
);

   logic [ADDR_W-1:0] ctrl_ofs;

   generate
      if (ADDR_W < 5) begin : g_addr_too_narrow
         $error("cdt_regs: ADDR_W must cover offset 0x1C");
      end
      if (DATA_W < CTRL_BITS) begin : g_data_too_narrow
         $error("cdt_regs: DATA_W narrower than the control field");
      end
      if (CTRL_AT_1C) begin : g_ctrl_hi
         assign ctrl_ofs = ADDR_W'(OFS_CTRL_B);
      end else begin : g_ctrl_lo
         assign ctrl_ofs = ADDR_W'(OFS_CTRL_A);
      end
   endgenerate

   logic [DATA_W-1:0] load_lo_q;
   logic [DATA_W-1:0] load_hi_q;
   ctrl_t             ctrl_q;
   logic              flag_q;

   logic hit_lo;
   logic hit_hi;
   logic hit_ctrl;
   logic hit_stat;
   logic clr_req;
   logic wdata_unused;

   assign hit_lo   = bus_addr == ADDR_W'(OFS_LOAD_LO);
   assign hit_hi   = bus_addr == ADDR_W'(OFS_LOAD_HI);
   assign hit_ctrl = bus_addr == ctrl_ofs;
   assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
   assign clr_req  = bus_wr & hit_stat & bus_wdata[0];

   assign wdata_unused = ^bus_wdata[DATA_W-1:CTRL_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_lo_q <= '0;
         load_hi_q <= '0;
         ctrl_q    <= '0;
      end else if (bus_wr) begin
         if (hit_lo)   load_lo_q <= bus_wdata;
         if (hit_hi)   load_hi_q <= bus_wdata;
         if (hit_ctrl) ctrl_q    <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      end
   end

   // set has priority over a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;
      else if (clr_req)  flag_q <= 1'b0;
   end

   assign load_o = {load_hi_q, load_lo_q};
   assign ctrl_o = ctrl_q;
   assign flag_o = flag_q;

   always_comb begin
      bus_rdata = '0;
      if (hit_lo)
         bus_rdata = load_lo_q;
      else if (hit_hi)
         bus_rdata = load_hi_q;
      else if (bus_addr == ADDR_W'(OFS_CNT_LO))
         bus_rdata = cnt_i[DATA_W-1:0];
      else if (bus_addr == ADDR_W'(OFS_CNT_HI))
         bus_rdata = cnt_i[CNT_W-1:DATA_W];
      else if (hit_ctrl)
         bus_rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_q};
      else if (hit_stat)
         bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
   end

   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && clr_req) |=> flag_q);

   // R7
   clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !expire_i) |=> !flag_q);

   // R7
   zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_stat && !bus_wdata[0] && flag_q) |=> flag_q);

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
   import cdt_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 5,
   parameter bit          CTRL_AT_1C = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int unsigned CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0] load;
   logic [CNT_W-1:0] cnt;
   ctrl_t            ctrl;
   logic             flag;
   logic             expire;

   cdt_regs #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .CTRL_AT_1C (CTRL_AT_1C)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt_i     (cnt),
      .expire_i  (expire),
      .load_o    (load),
      .ctrl_o    (ctrl),
      .flag_o    (flag)
   );

   cdt_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ctrl_i   (ctrl),
      .load_i   (load),
      .cnt_o    (cnt),
      .expire_o (expire)
   );

   assign irq = flag & ctrl.unmask;

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($rose(flag) || $rose(ctrl.unmask)));

endmodule

// File: tb/cdown_timer_bench.sv
module cdown_timer_bench;

   localparam int unsigned DW = 32;
   localparam int unsigned AW = 5;
   localparam logic [AW-1:0] A_LLO  = 5'h00;
   localparam logic [AW-1:0] A_LHI  = 5'h04;
   localparam logic [AW-1:0] A_CLO  = 5'h08;
   localparam logic [AW-1:0] A_CHI  = 5'h0C;
   localparam logic [AW-1:0] A_CTRL = 5'h10;
   localparam logic [AW-1:0] A_STAT = 5'h18;
   localparam logic [AW-1:0] A_OTH  = 5'h1C;

   typedef struct {
      logic [DW-1:0] data;
      logic          irq;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;
   logic          rd_req = 1'b0;
   logic          done = 1'b0;

   int   total = 0;
   int   bad = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   cdown_timer #(.DATA_W(DW), .ADDR_W(AW), .CTRL_AT_1C(1'b0)) u_cdown_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // each task occupies one clock window, starting just after an edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk); #1;
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic q, input string tag);
      exp_t e;
      e.data = d; e.irq = q; e.tag = tag;
      sb.push_back(e);
      bus_addr = a;
      rd_req   = 1'b1;
      @(posedge clk); #1;
      rd_req   = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   // monitor: compares at the falling edge, mid-window
   always @(negedge clk) begin
      if (rd_req) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (bus_rdata !== e.data || irq !== e.irq) begin
            bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     e.tag, bus_rdata, irq, e.data, e.irq);
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R2 unmapped offset
      rd(A_LLO, 0, 0, "R1 reload low");
      rd(A_LHI, 0, 0, "R1 reload high");
      rd(A_CLO, 0, 0, "R1 count low");
      rd(A_CHI, 0, 0, "R1 count high");
      rd(A_CTRL, 0, 0, "R1 control");
      rd(A_STAT, 0, 0, "R1 flag");
      rd(A_OTH, 0, 0, "R2 unmapped reads zero");

      // periodic mode, reload 3
      wr(A_LLO, 3);
      wr(A_LHI, 0);
      wr(A_CTRL, 32'h5);
      idle(1);
      rd(A_CLO, 3, 0, "R3 start loads");
      rd(A_CLO, 2, 0, "R4 step");
      rd(A_CLO, 1, 0, "R4 step");
      rd(A_CLO, 0, 0, "R4 step");
      rd(A_STAT, 1, 1, "R5 expiry sets flag");
      wr(A_STAT, 1);
      rd(A_STAT, 0, 0, "R7 clear");
      rd(A_STAT, 0, 0, "R5 period not early");
      rd(A_STAT, 1, 1, "R5 period N+1");
      wr(A_STAT, 1);
      idle(1);
      wr(A_STAT, 1);
      rd(A_STAT, 1, 1, "R8 set beats clear");
      wr(A_CTRL, 32'h1);
      rd(A_STAT, 1, 0, "R9 masked irq");
      rd(A_CLO, 0, 0, "R3 rewrite does not reload");
      rd(A_LLO, 3, 0, "R2 reload readback");

      // stop freezes the count
      wr(A_LLO, 100);
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h1);
      idle(1);
      rd(A_CLO, 100, 0, "R3 restart loads");
      rd(A_CLO, 99, 0, "R4 step");
      wr(A_CTRL, 0);
      rd(A_CLO, 97, 0, "R4 stop freezes");
      rd(A_CLO, 97, 0, "R4 stop freezes");

      // single-shot mode, reload 2
      wr(A_LLO, 2);
      wr(A_STAT, 1);
      wr(A_CTRL, 32'h7);
      idle(1);
      rd(A_CLO, 2, 0, "R6 start");
      rd(A_CLO, 1, 0, "R6 step");
      rd(A_CLO, 0, 0, "R6 step");
      rd(A_STAT, 1, 1, "R6 expiry sets flag");
      wr(A_STAT, 0);
      rd(A_STAT, 1, 1, "R7 zero write no effect");
      wr(A_STAT, 1);
      rd(A_STAT, 0, 0, "R6 no second expiry");
      rd(A_CLO, 0, 0, "R6 holds zero");
      rd(A_CTRL, 7, 0, "R6 run bit kept");
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h7);
      idle(1);
      rd(A_CLO, 2, 0, "R6 restart after 0-1");

      // 64-bit borrow and tick gating
      wr(A_LLO, 0);
      wr(A_LHI, 1);
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h1);
      idle(1);
      rd(A_CHI, 1, 0, "R10 high word loaded");
      rd(A_CLO, 32'hFFFF_FFFF, 0, "R10 borrow low");
      rd(A_CHI, 0, 0, "R10 borrow high");
      tick = 1'b0;
      rd(A_CLO, 32'hFFFF_FFFD, 0, "R4 last tick");
      rd(A_CLO, 32'hFFFF_FFFD, 0, "R4 no tick holds");
      tick = 1'b1;
      rd(A_LHI, 1, 0, "R2 reload high readback");

      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog: run hung, done=%b expected 1", done);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule